// File: doc/BRIEF.md
# Load/Store Base-Plus-Offset Address Generator

This block forms the memory address for a single load or store, together with the new value of the base register and a flag that says whether that value is to be written back. Each request carries a base register value, an offset source, a direction bit and an indexing mode. The offset is either a 12-bit immediate, zero-extended, or a register value shifted logically left by an amount taken from the instruction. The direction bit chooses whether the offset is added to or subtracted from the base. All arithmetic is 32 bits wide and wraps modulo 2^32.

The indexing mode decides which value goes to memory and which value is written back. Plain offset mode sends the adjusted address to memory and updates nothing. Pre-update mode sends the adjusted address and also writes it back. Post-update mode sends the untouched base to memory and writes back the adjusted base. Results are registered and appear one cycle after the request, flagged by a response valid.

Top module: `ls_addr_gen`

## Requirements
- R1: While `rstN` is low, `rspValid`, `wbEnable`, `accessAddr` and `wbValue` are all zero.
- R2: With `indexMode` = 2'b00 (plain offset), `accessAddr` and `wbValue` both equal base plus or minus the offset, and `wbEnable` is 0.
- R3: With `indexMode` = 2'b01 (pre-update), `accessAddr` and `wbValue` both equal base plus or minus the offset, and `wbEnable` is 1.
- R4: With `indexMode` = 2'b10 (post-update), `accessAddr` equals the unmodified base, `wbValue` equals base plus or minus the offset, and `wbEnable` is 1.
- R5: `subtract` = 1 subtracts the offset from the base and `subtract` = 0 adds it. Both wrap modulo 2^32 with no carry or borrow out.
- R6: With `useRegOffset` = 0, the offset is `immOffset` zero-extended to 32 bits, and `shiftAmt` has no effect.
- R7: With `useRegOffset` = 1, the offset is `regOffset` shifted logically left by `shiftAmt` (0 to 31). Bits shifted past bit 31 are lost and zeros fill from the right.
- R8: A request sampled with `reqValid` high at a rising edge produces its results, with `rspValid` high, right after the next rising edge. `wbEnable` is never high while `rspValid` is low.
- R9: At a rising edge where `reqValid` is low, `rspValid` drops to 0 and `accessAddr` and `wbValue` keep their previous values.
- R10: `indexMode` = 2'b11 behaves exactly like plain offset mode (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| baseVal | input | 32 | Base register value |
| immOffset | input | 12 | Immediate offset, unsigned |
| regOffset | input | 32 | Register offset value before shifting |
| useRegOffset | input | 1 | 1 selects the shifted register offset, 0 selects the immediate |
| shiftAmt | input | 5 | Left shift applied to the register offset |
| subtract | input | 1 | 1 subtracts the offset, 0 adds it |
| indexMode | input | 2 | 00 plain offset, 01 pre-update, 10 post-update, 11 same as 00 |
| rspValid | output | 1 | Results valid this cycle |
| accessAddr | output | 32 | Address for the memory access |
| wbValue | output | 32 | New base register value |
| wbEnable | output | 1 | Write `wbValue` back to the base register |

## Verification
The assertions assume that the request inputs are settled and known at every rising edge, including `indexMode` and `reqValid`. This matters because the mode and hold checks compare outputs against the sampled values of the previous cycle. The stimulus changes inputs only on falling edges and drives every input to a defined value before reset is released, so every sample the properties take sees stable, known values. The stimulus mixes back-to-back requests with idle gaps, and it steers operands to the wrap, maximum-shift and maximum-immediate corners.

// File: rtl/ls_addr_gen_pkg.sv
package ls_addr_gen_pkg;

  typedef enum logic [1:0] {
    IDX_OFFSET = 2'b00,
    IDX_PRE    = 2'b01,
    IDX_POST   = 2'b10,
    IDX_ALT    = 2'b11
  } idxMode_e;

  // strobes from control to datapath, valid in the request cycle
  typedef struct packed {
    logic capture;      // load result registers this cycle
    logic addrFromSum;  // memory address takes the adjusted base
    logic useReg;       // shifted register offset instead of immediate
    logic doSub;        // subtract the offset
  } agStrobes_t;

endpackage

// File: rtl/ls_addr_gen_ctrl.sv
module ls_addr_gen_ctrl
  import ls_addr_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] indexMode,
  input  logic       useRegOffset,
  input  logic       subtract,
  output agStrobes_t strobes,
  output logic       rspValid,
  output logic       wbEnable
);

  logic wantsWb;

  always_comb begin
    strobes.capture     = reqValid;
    strobes.useReg      = useRegOffset;
    strobes.doSub       = subtract;
    strobes.addrFromSum = 1'b1;
    wantsWb             = 1'b0;
    unique case (indexMode)
      IDX_PRE:  begin strobes.addrFromSum = 1'b1; wantsWb = 1'b1; end
      IDX_POST: begin strobes.addrFromSum = 1'b0; wantsWb = 1'b1; end
      default:  begin strobes.addrFromSum = 1'b1; wantsWb = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      wbEnable <= 1'b0;
    end else begin
      rspValid <= reqValid;
      wbEnable <= reqValid & wantsWb;
    end
  end

  // R2 / R10: plain offset and the alternate encoding never write back
  a_r2_offset_no_wb: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (indexMode == IDX_OFFSET || indexMode == IDX_ALT) |=> rspValid && !wbEnable);

  // R3 / R4: update modes do write back
  a_r3_update_wb: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (indexMode == IDX_PRE || indexMode == IDX_POST) |=> rspValid && wbEnable);

  // R8: writeback only alongside a valid response
  a_r8_wb_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    wbEnable |-> rspValid);

  // R9: no request means no response next cycle
  a_r9_idle_no_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

endmodule

// File: rtl/ls_addr_gen_dpath.sv
module ls_addr_gen_dpath
  import ls_addr_gen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  agStrobes_t        strobes,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [IMM_W-1:0]  immOffset,
  input  logic [DATA_W-1:0] regOffset,
  input  logic [SH_W-1:0]   shiftAmt,
  output logic [DATA_W-1:0] accessAddr,
  output logic [DATA_W-1:0] wbValue
);

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] regShifted;
  logic [DATA_W-1:0] offsetVal;
  logic [DATA_W-1:0] adjusted;

  generate
    if (IMM_W < DATA_W) begin : g_imm_pad
      assign immExt = {{(DATA_W-IMM_W){1'b0}}, immOffset};
    end else begin : g_imm_trim
      assign immExt = immOffset[DATA_W-1:0];
    end
  endgenerate

  assign regShifted = regOffset << shiftAmt;

  always_comb begin
    offsetVal = strobes.useReg ? regShifted : immExt;
    adjusted  = strobes.doSub ? (baseVal - offsetVal) : (baseVal + offsetVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accessAddr <= '0;
      wbValue    <= '0;
    end else if (strobes.capture) begin
      accessAddr <= strobes.addrFromSum ? adjusted : baseVal;
      wbValue    <= adjusted;
    end
  end

  // R4: post-update sends the base untouched
  a_r4_post_base_addr: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture && !strobes.addrFromSum |=> accessAddr == $past(baseVal));

  // R9: results hold without a request
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(accessAddr) && $stable(wbValue));

  // R6: an immediate offset below the width never depends on the shift
  a_r6_imm_range: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture && strobes.useReg == 1'b0 && strobes.doSub == 1'b0 && strobes.addrFromSum
    |=> (accessAddr - $past(baseVal)) == $past(immExt));

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
  import ls_addr_gen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [IMM_W-1:0]  immOffset,
  input  logic [DATA_W-1:0] regOffset,
  input  logic              useRegOffset,
  input  logic [SH_W-1:0]   shiftAmt,
  input  logic              subtract,
  input  logic [1:0]        indexMode,
  output logic              rspValid,
  output logic [DATA_W-1:0] accessAddr,
  output logic [DATA_W-1:0] wbValue,
  output logic              wbEnable
);

  agStrobes_t strobes;

  ls_addr_gen_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .indexMode    (indexMode),
    .useRegOffset (useRegOffset),
    .subtract     (subtract),
    .strobes      (strobes),
    .rspValid     (rspValid),
    .wbEnable     (wbEnable)
  );

  ls_addr_gen_dpath #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .baseVal    (baseVal),
    .immOffset  (immOffset),
    .regOffset  (regOffset),
    .shiftAmt   (shiftAmt),
    .accessAddr (accessAddr),
    .wbValue    (wbValue)
  );

  // R3: pre-update sends and writes back the same value
  a_r3_pre_same: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && indexMode == IDX_PRE |=> accessAddr == wbValue);

  // R2: plain offset also sends the adjusted value that wbValue carries
  a_r2_addr_is_adjusted: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && indexMode == IDX_OFFSET |=> accessAddr == wbValue);

endmodule

// File: tb/ls_addr_gen_tb_top.sv
module ls_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] baseVal = '0;
  logic [11:0] immOffset = '0;
  logic [31:0] regOffset = '0;
  logic        useRegOffset = 1'b0;
  logic [4:0]  shiftAmt = '0;
  logic        subtract = 1'b0;
  logic [1:0]  indexMode = 2'b00;
  logic        rspValid;
  logic [31:0] accessAddr;
  logic [31:0] wbValue;
  logic        wbEnable;

  always #10 clk = ~clk;  // 50 MHz

  ls_addr_gen dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .baseVal(baseVal),
    .immOffset(immOffset), .regOffset(regOffset), .useRegOffset(useRegOffset),
    .shiftAmt(shiftAmt), .subtract(subtract), .indexMode(indexMode),
    .rspValid(rspValid), .accessAddr(accessAddr), .wbValue(wbValue),
    .wbEnable(wbEnable)
  );

  typedef struct {
    logic [31:0] addr;
    logic [31:0] wb;
    logic        wbEn;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  logic [31:0] lastAddr = '0;
  logic [31:0] lastWb = '0;

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic expItem_t model(logic [31:0] b, logic [11:0] imm, logic [31:0] r,
                                     logic useR, logic [4:0] sh, logic sub, logic [1:0] m,
                                     string tag);
    expItem_t e;
    logic [31:0] off;
    logic [31:0] sum;
    off = useR ? (r << sh) : {20'd0, imm};
    sum = sub ? b - off : b + off;
    e.tag = tag;
    e.wb  = sum;
    if (m == 2'b10) begin e.addr = b; e.wbEn = 1'b1; end
    else if (m == 2'b01) begin e.addr = sum; e.wbEn = 1'b1; end
    else begin e.addr = sum; e.wbEn = 1'b0; end
    return e;
  endfunction

  task automatic drive(logic [31:0] b, logic [11:0] imm, logic [31:0] r, logic useR,
                       logic [4:0] sh, logic sub, logic [1:0] m, string tag);
    @(negedge clk);
    reqValid = 1'b1; baseVal = b; immOffset = imm; regOffset = r;
    useRegOffset = useR; shiftAmt = sh; subtract = sub; indexMode = m;
    expQ.push_back(model(b, imm, r, useR, sh, sub, m, tag));
  endtask

  task automatic idle(logic [31:0] junk);
    @(negedge clk);
    reqValid = 1'b0; baseVal = junk; immOffset = junk[11:0]; regOffset = ~junk;
    useRegOffset = junk[0]; shiftAmt = junk[4:0]; subtract = junk[1]; indexMode = junk[3:2];
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    if (monOn) begin
      #2;
      if (rspValid) begin
        if (expQ.size() == 0) begin
          check32("R8", "unexpected rspValid", 32'd1, 32'd0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check32(e.tag, "accessAddr", accessAddr, e.addr);
          check32(e.tag, "wbValue", wbValue, e.wb);
          check32(e.tag, "wbEnable", {31'd0, wbEnable}, {31'd0, e.wbEn});
          lastAddr = e.addr;
          lastWb = e.wb;
        end
      end else begin
        check32("R8", "missing rspValid", {31'd0, rspValid}, {31'd0, (expQ.size() != 0)});
        check32("R8", "wbEnable without rspValid", {31'd0, wbEnable}, 32'd0);
        check32("R9", "accessAddr hold", accessAddr, lastAddr);
        check32("R9", "wbValue hold", wbValue, lastWb);
        if (expQ.size() != 0) void'(expQ.pop_front());
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state with requests present on the inputs
    reqValid = 1'b1; baseVal = 32'h1234_5678; immOffset = 12'hABC; indexMode = 2'b01;
    repeat (3) @(posedge clk);
    #3;
    check32("R1", "rspValid in reset", {31'd0, rspValid}, 32'd0);
    check32("R1", "wbEnable in reset", {31'd0, wbEnable}, 32'd0);
    check32("R1", "accessAddr in reset", accessAddr, 32'd0);
    check32("R1", "wbValue in reset", wbValue, 32'd0);
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;

    // R2 plain offset, add immediate
    drive(32'h0000_1000, 12'h010, 32'h0, 1'b0, 5'd0, 1'b0, 2'b00, "R2");
    // R3 pre-update, subtract immediate
    drive(32'h0000_1000, 12'h004, 32'h0, 1'b0, 5'd0, 1'b1, 2'b01, "R3");
    // R4 post-update, add register
    drive(32'h8000_0000, 12'h0, 32'h0000_0020, 1'b1, 5'd0, 1'b0, 2'b10, "R4");
    // R5 wrap on add and on subtract
    drive(32'hFFFF_FFFF, 12'h001, 32'h0, 1'b0, 5'd0, 1'b0, 2'b01, "R5");
    drive(32'h0000_0000, 12'h001, 32'h0, 1'b0, 5'd0, 1'b1, 2'b10, "R5");
    // R6 max immediate, shift amount must not apply
    drive(32'h0000_0100, 12'hFFF, 32'hDEAD_BEEF, 1'b0, 5'd31, 1'b0, 2'b00, "R6");
    drive(32'h0001_0000, 12'hFFF, 32'h0, 1'b0, 5'd7, 1'b1, 2'b01, "R6");
    // R7 register shifts: 31, bits lost, and mid
    drive(32'h0000_0000, 12'h0, 32'h0000_0003, 1'b1, 5'd31, 1'b0, 2'b01, "R7");
    drive(32'h1000_0000, 12'h0, 32'hF000_000F, 1'b1, 5'd4, 1'b1, 2'b00, "R7");
    drive(32'h0000_4000, 12'h0, 32'h0000_0001, 1'b1, 5'd12, 1'b0, 2'b10, "R7");
    // R10 alternate encoding behaves like plain offset
    drive(32'h0000_2000, 12'h123, 32'h0, 1'b0, 5'd0, 1'b0, 2'b11, "R10");
    drive(32'h0000_2000, 12'h0, 32'h0000_0011, 1'b1, 5'd2, 1'b1, 2'b11, "R10");
    // R9 idle gaps with changing junk on inputs
    idle(32'hA5A5_5A5F);
    idle(32'h5A5A_A5AE);
    drive(32'h0000_0040, 12'h008, 32'h0, 1'b0, 5'd0, 1'b0, 2'b01, "R8");
    idle(32'hFFFF_FFFF);
    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      logic [31:0] rb, rr;
      logic [31:0] rc;
      rb = $urandom; rr = $urandom; rc = $urandom;
      if (rc[27:25] == 3'd0) idle(rc);
      else drive(rb, rc[11:0], rr, rc[12], rc[17:13], rc[18], rc[20:19],
                 rc[12] ? "R7" : "R6");
    end
    idle(32'h0);
    idle(32'h0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule